// File: doc/BRIEF.md
# Event Output Router

This block selects one internal event and presents it on a single output pin. Two alarm flags are held inside the block. Each flag is set by an alarm event pulse and cleared either by a software strobe or, when auto-clear is on, by the first prescaler tick after it was set. The wake-up flag and the tamper flag arrive as levels from elsewhere in the chip.

A 2-bit select field picks which flag is routed to the pin. A tamper-route enable ORs the tamper flag onto that selection. A polarity bit sets whether the active level is high or low. An output-type bit chooses how the pin is driven. In push-pull mode the pin is always driven. In open-drain mode the block drives only a low level and otherwise releases the pin through its output-enable.

The pin level and the output-enable are registered, so a change in a routed flag reaches the pin one clock later.

Top module: `evr_router`

## Requirements
- R1: After synchronous reset, both alarm flags read 0, the pin level is 0 and the output-enable is 1.
- R2: Select code 0 routes nothing, code 1 routes alarm flag 0 (A), code 2 routes alarm flag 1 (B) and code 3 routes the wake-up flag.
- R3: When the tamper-route enable is 1, the tamper flag is ORed with the selected flag. When it is 0, the tamper flag has no effect on the pin.
- R4: With polarity 0 the pin is high while the routed signal is asserted. With polarity 1 the pin is low while it is asserted. With select 0 and tamper routing off, the pin rests at the inactive level (0 for polarity 0, 1 for polarity 1).
- R5: An alarm event seen while its flag is 0 sets the flag on the next clock edge.
- R6: With auto-clear off, a set alarm flag stays 1 until a software clear. An alarm event that arrives while the flag is 1 is dropped, so the flag stays 0 after the clear.
- R7: With auto-clear on, a set alarm flag is cleared at the first clock edge on which the prescaler tick input is 1.
- R8: A software clear strobe on a set alarm flag clears it at the next clock edge. A clear strobe takes priority over an event in the same cycle.
- R9: In push-pull mode (output-type 0) the output-enable is 1. In open-drain mode (output-type 1) the output-enable is 1 exactly when the pin level is 0.
- R10: The pin level and the output-enable reflect the flags and control inputs as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler tick strobe |
| alarm_evt_i | input | 2 | Alarm event pulses, bit 0 = A, bit 1 = B |
| alarm_clr_i | input | 2 | Software clear strobes per alarm flag |
| alarm_autoclr_i | input | 2 | Auto-clear enable per alarm flag |
| wake_flag_i | input | 1 | Wake-up flag level |
| tamper_flag_i | input | 1 | Tamper flag level |
| route_sel_i | input | 2 | Select code: 0 off, 1 A, 2 B, 3 wake-up |
| tamper_route_i | input | 1 | OR the tamper flag onto the pin |
| invert_i | input | 1 | Polarity: 1 makes the active level low |
| open_drain_i | input | 1 | Output type: 0 push-pull, 1 open-drain |
| alarm_flag_o | output | 2 | Alarm flags A and B |
| pin_o | output | 1 | Registered pin level |
| pin_oe_o | output | 1 | Registered pin output-enable |

## Verification
A wrong internal state in this block is a stuck or spuriously set alarm flag. Such a flag shows up on `alarm_flag_o` at the clock edge that should have changed it. When that alarm is selected, the fault also reaches `pin_o` one edge later. A queued event that should have been dropped would make a flag rise just after its clear. An auto-clear fault would show as a flag still high after a tick. Both are visible within two cycles, at the flag port and then at the pin.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2,
    SEL_WAKE = 2'd3
  } evr_sel_e;

  localparam int unsigned EVR_ALARMS = 2;
endpackage

// File: rtl/evr_alarm_flag.sv
module evr_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  input  logic autoclr_i,
  input  logic tick_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (flag_o) begin
      if (clr_i || (autoclr_i && tick_i)) flag_o <= 1'b0;
    end else if (evt_i) begin
      flag_o <= 1'b1;
    end
  end

  a_r5_set: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && evt_i) |=> flag_o);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i && !(autoclr_i && tick_i)) |=> flag_o);
  a_r7_autoclear: assert property (@(posedge clk) disable iff (rst)
    (flag_o && autoclr_i && tick_i) |=> !flag_o);
  a_r8_swclear: assert property (@(posedge clk) disable iff (rst)
    (flag_o && clr_i) |=> !flag_o);
endmodule

// File: rtl/evr_route_mux.sv
module evr_route_mux
  import evr_pkg::*;
(
  input  logic [EVR_ALARMS-1:0] alarm_flag_i,
  input  logic                  wake_flag_i,
  input  logic                  tamper_flag_i,
  input  logic [1:0]            route_sel_i,
  input  logic                  tamper_route_i,
  output logic                  routed_o
);
  logic chosen;

  always_comb begin
    unique case (evr_sel_e'(route_sel_i))
      SEL_A:    chosen = alarm_flag_i[0];
      SEL_B:    chosen = alarm_flag_i[1];
      SEL_WAKE: chosen = wake_flag_i;
      default:  chosen = 1'b0;
    endcase
    routed_o = chosen | (tamper_route_i & tamper_flag_i);
  end
endmodule

// File: rtl/evr_pad_drive.sv
module evr_pad_drive (
  input  logic clk,
  input  logic rst,
  input  logic routed_i,
  input  logic invert_i,
  input  logic open_drain_i,
  output logic pin_o,
  output logic pin_oe_o
);
  logic level;

  always_comb level = routed_i ^ invert_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o    <= 1'b0;
      pin_oe_o <= 1'b1;
    end else begin
      pin_o    <= level;
      pin_oe_o <= open_drain_i ? ~level : 1'b1;
    end
  end

  a_r9_pushpull: assert property (@(posedge clk) disable iff (rst)
    !open_drain_i |=> pin_oe_o);
  a_r9_opendrain: assert property (@(posedge clk) disable iff (rst)
    open_drain_i |=> (pin_oe_o != pin_o));
endmodule

// File: rtl/evr_router.sv
module evr_router
  import evr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] alarm_evt_i,
  input  logic [1:0] alarm_clr_i,
  input  logic [1:0] alarm_autoclr_i,
  input  logic       wake_flag_i,
  input  logic       tamper_flag_i,
  input  logic [1:0] route_sel_i,
  input  logic       tamper_route_i,
  input  logic       invert_i,
  input  logic       open_drain_i,
  output logic [1:0] alarm_flag_o,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic routed;

  for (genvar g = 0; g < EVR_ALARMS; g++) begin : g_alarm
    evr_alarm_flag flag_i (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (alarm_evt_i[g]),
      .clr_i     (alarm_clr_i[g]),
      .autoclr_i (alarm_autoclr_i[g]),
      .tick_i    (tick_i),
      .flag_o    (alarm_flag_o[g])
    );
  end

  evr_route_mux mux_i (
    .alarm_flag_i   (alarm_flag_o),
    .wake_flag_i    (wake_flag_i),
    .tamper_flag_i  (tamper_flag_i),
    .route_sel_i    (route_sel_i),
    .tamper_route_i (tamper_route_i),
    .routed_o       (routed)
  );

  evr_pad_drive drive_i (
    .clk          (clk),
    .rst          (rst),
    .routed_i     (routed),
    .invert_i     (invert_i),
    .open_drain_i (open_drain_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    (route_sel_i == SEL_OFF && !tamper_route_i) |=> (pin_o == $past(invert_i)));
  a_r3_tamper_active: assert property (@(posedge clk) disable iff (rst)
    (tamper_route_i && tamper_flag_i) |=> (pin_o != $past(invert_i)));
  a_r2_route_a: assert property (@(posedge clk) disable iff (rst)
    (route_sel_i == SEL_A && !tamper_route_i) |=> (pin_o == ($past(alarm_flag_o[0]) ^ $past(invert_i))));
endmodule

// File: tb/evr_router_tb_top.sv
module evr_router_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic tick_i;
  logic [1:0] alarm_evt_i, alarm_clr_i, alarm_autoclr_i;
  logic wake_flag_i, tamper_flag_i;
  logic [1:0] route_sel_i;
  logic tamper_route_i, invert_i, open_drain_i;
  logic [1:0] alarm_flag_o;
  logic pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_flag;
  logic m_pin, m_oe;

  always #2.5 clk = ~clk;

  evr_router dut_i (.*);

  function automatic logic nxt_flag(logic f, logic e, logic c, logic a, logic t);
    if (f) return !(c || (a && t));
    return e;
  endfunction

  function automatic logic route_of(logic [1:0] f, logic w, logic tp, logic [1:0] s, logic te);
    logic ch;
    case (s)
      2'd1: ch = f[0];
      2'd2: ch = f[1];
      2'd3: ch = w;
      default: ch = 1'b0;
    endcase
    return ch | (te & tp);
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one clock edge: advance the model from pre-edge inputs, then compare
  task automatic cyc();
    logic lvl;
    @(posedge clk);
    lvl = route_of(m_flag, wake_flag_i, tamper_flag_i, route_sel_i, tamper_route_i) ^ invert_i;
    m_pin = lvl;
    m_oe  = open_drain_i ? ~lvl : 1'b1;
    for (int i = 0; i < 2; i++)
      m_flag[i] = nxt_flag(m_flag[i], alarm_evt_i[i], alarm_clr_i[i], alarm_autoclr_i[i], tick_i);
    #1;
    check("R5 flags", alarm_flag_o, m_flag);
    check("R2 pin", {1'b0, pin_o}, {1'b0, m_pin});
    check("R9 oe", {1'b0, pin_oe_o}, {1'b0, m_oe});
  endtask

  task automatic idle_inputs();
    tick_i = 0; alarm_evt_i = 0; alarm_clr_i = 0; alarm_autoclr_i = 0;
    wake_flag_i = 0; tamper_flag_i = 0; route_sel_i = 0;
    tamper_route_i = 0; invert_i = 0; open_drain_i = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst = 1;
    m_flag = 0; m_pin = 0; m_oe = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    check("R1 reset flags", alarm_flag_o, 2'b00);
    check("R1 reset pin/oe", {pin_o, pin_oe_o}, 2'b01);

    // R5 / R6: manual clear, second event while set is dropped
    route_sel_i = 2'd1;
    alarm_evt_i = 2'b01; cyc();
    alarm_evt_i = 2'b00;
    check("R5 set A", alarm_flag_o, 2'b01);
    cyc();
    check("R2 A routed to pin", {1'b0, pin_o}, 2'b01);
    tick_i = 1; alarm_evt_i = 2'b01; cyc();
    tick_i = 0; alarm_evt_i = 0;
    check("R6 held without autoclear", alarm_flag_o, 2'b01);
    alarm_clr_i = 2'b01; alarm_evt_i = 2'b01; cyc();
    alarm_clr_i = 0; alarm_evt_i = 0;
    check("R8 clear beats event", alarm_flag_o, 2'b00);
    cyc();
    check("R6 dropped event not queued", alarm_flag_o, 2'b00);

    // R7: auto-clear on flag B
    alarm_autoclr_i = 2'b10; route_sel_i = 2'd2;
    alarm_evt_i = 2'b10; tick_i = 1; cyc();
    alarm_evt_i = 0;
    check("R7 set in tick cycle", alarm_flag_o, 2'b10);
    tick_i = 0; cyc();
    check("R7 held until tick", alarm_flag_o, 2'b10);
    tick_i = 1; cyc();
    tick_i = 0;
    check("R7 cleared on tick", alarm_flag_o, 2'b00);
    alarm_autoclr_i = 0;

    // R3: tamper ORed and ignored when routing off
    route_sel_i = 0; tamper_flag_i = 1; tamper_route_i = 1; cyc();
    check("R3 tamper routed", {1'b0, pin_o}, 2'b01);
    tamper_route_i = 0; cyc();
    check("R3 tamper ignored", {1'b0, pin_o}, 2'b00);
    tamper_flag_i = 0;

    // R4: idle level with inverted polarity
    invert_i = 1; cyc();
    check("R4 inactive level inverted", {1'b0, pin_o}, 2'b01);
    // R9: open-drain releases inactive-high level
    open_drain_i = 1; cyc();
    check("R9 open-drain release", {pin_o, pin_oe_o}, 2'b10);

    // R10: one-edge latency for wake-up route
    route_sel_i = 2'd3; wake_flag_i = 1; #1;
    check("R10 pin before edge", {1'b0, pin_o}, 2'b01);
    cyc();
    check("R10 pin after edge", {pin_o, pin_oe_o}, 2'b01);
    idle_inputs(); cyc();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      tick_i          = ($urandom_range(3) == 0);
      alarm_evt_i     = {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
      alarm_clr_i     = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      if ($urandom_range(31) == 0) alarm_autoclr_i = 2'($urandom);
      wake_flag_i     = ($urandom_range(3) == 0) ? ~wake_flag_i : wake_flag_i;
      tamper_flag_i   = ($urandom_range(5) == 0);
      if ($urandom_range(15) == 0) route_sel_i = 2'($urandom);
      if ($urandom_range(15) == 0) tamper_route_i = 1'($urandom);
      if ($urandom_range(31) == 0) invert_i = 1'($urandom);
      if ($urandom_range(31) == 0) open_drain_i = 1'($urandom);
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule